// File: doc/BRIEF.md
# Serial Flash Configuration and Soft-Reset Unit

This block keeps the configuration state of a serial NOR flash slave: a 16-bit nonvolatile configuration word, an 8-bit volatile configuration byte, an 8-bit enhanced volatile byte, an extended address register and the 4-byte addressing flag. It sits behind a command front end. The front end hands it decoded opcodes and the data bytes collected after them. It returns the byte to shift out while a register read is in progress, and it signals the release of chip select.

Software resets the part with two consecutive opcodes: an arming opcode followed directly by the reset opcode. A reset, or the power-on reset, rebuilds the volatile byte, the enhanced byte, the extended address and the 4-byte flag from the nonvolatile word. The nonvolatile word itself is left unchanged. Register writes are gated by the write enable latch. A write lands only when its last data byte arrives.

Top module: `spi_cfg_unit`

## Requirements
- R1: After power-on reset, cfg_nv is NV_INIT (default 0x8FFF) and the other state follows from it by R4 to R6. For the default this gives cfg_v=0x83, cfg_ev=0xDF, ext_addr=0, addr4_mode=0 and write_en=0.
- R2: Opcode 0x66 arms the unit, and any other opcode disarms it. Opcode 0x99 starts a reset only when the opcode just before it was 0x66. soft_rst is high for exactly the one cycle after the 0x99 clock edge.
- R3: A software reset clears write_en. It abandons any pending write and any read in progress, so rd_byte reads 0x00 until a new read opcode arrives.
- R4: On reset, cfg_v bits [1:0] become 1 and bit 2 becomes 0. Bit 3 is 1 unless cfg_nv[11:9] is 3'b111, and bits [7:4] copy cfg_nv[15:12].
- R5: On reset, cfg_ev bits [4:0] become 5'h1F and bit 5 becomes 0. Bit 6 copies cfg_nv[2] and bit 7 copies cfg_nv[3].
- R6: On reset, addr4_mode becomes the inverse of cfg_nv[0]. ext_addr becomes UPPER_SEG (default 3) when cfg_nv[1] is 0, and 0 otherwise.
- R7: Read opcodes: 0xB5 returns cfg_nv as two bytes, low byte first. 0x85 returns cfg_v, 0x65 returns cfg_ev and 0xC8 returns ext_addr, each as one byte. rd_byte shows the current byte, and rd_req moves to the next one. Past the last byte, rd_byte reads 0x00.
- R8: Write opcodes: 0xB1 writes cfg_nv (two bytes, low byte first). 0x81 writes cfg_v, 0x61 writes cfg_ev and 0xC5 writes ext_addr (one byte each). When write_en is 0, the opcode and its data bytes are ignored.
- R9: A write changes its register on the clock edge of its last data byte. If frame_end arrives first, the write is discarded. Bytes after the last one are ignored.
- R10: 0x06 sets write_en and 0x04 clears it. 0xB7 sets addr4_mode and 0xE9 clears it.
- R11: A software reset leaves cfg_nv unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| op_valid | input | 1 | Decoded opcode present this cycle |
| op_code | input | 8 | Opcode value |
| data_valid | input | 1 | Collected data byte present this cycle |
| data_byte | input | 8 | Data byte value |
| frame_end | input | 1 | Chip select released |
| rd_req | input | 1 | Current read byte consumed, advance |
| rd_byte | output | 8 | Byte to shift out |
| cfg_nv | output | 16 | Nonvolatile configuration word |
| cfg_v | output | 8 | Volatile configuration byte |
| cfg_ev | output | 8 | Enhanced volatile byte |
| ext_addr | output | EAR_W | Extended address register |
| addr4_mode | output | 1 | 4-byte addressing active |
| write_en | output | 1 | Write enable latch |
| soft_rst | output | 1 | One-cycle pulse after a software reset |

## Verification
The bench separates the arming opcode from the reset opcode with a third opcode, and it also issues the reset opcode with nothing armed. A design that remembers the arm across other opcodes would produce a reset pulse in these cases. Writes are tried without write enable, cut short by frame_end, and followed by surplus bytes. A design that commits early would show a half-written word, and one that ignores the gate would show a changed register. Two different nonvolatile words are pushed through the reset derivation, so every derived bit is checked at both values. A read runs past its length to expose a design that wraps around or repeats the last byte.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

   localparam logic [7:0] OP_ARM    = 8'h66;
   localparam logic [7:0] OP_RST    = 8'h99;
   localparam logic [7:0] OP_WEN    = 8'h06;
   localparam logic [7:0] OP_WDIS   = 8'h04;
   localparam logic [7:0] OP_A4_ON  = 8'hB7;
   localparam logic [7:0] OP_A4_OFF = 8'hE9;
   localparam logic [7:0] OP_RD_NV  = 8'hB5;
   localparam logic [7:0] OP_WR_NV  = 8'hB1;
   localparam logic [7:0] OP_RD_V   = 8'h85;
   localparam logic [7:0] OP_WR_V   = 8'h81;
   localparam logic [7:0] OP_RD_EV  = 8'h65;
   localparam logic [7:0] OP_WR_EV  = 8'h61;
   localparam logic [7:0] OP_RD_EA  = 8'hC8;
   localparam logic [7:0] OP_WR_EA  = 8'hC5;

   typedef enum logic [2:0] {
      TGT_NONE,
      TGT_NV,
      TGT_V,
      TGT_EV,
      TGT_EA
   } tgt_e;

   typedef struct packed {
      logic [7:0] v;
      logic [7:0] ev;
      logic       a4;
      logic       upper;
   } derived_t;

   // volatile state rebuilt from the nonvolatile word
   function automatic derived_t derive_cfg(input logic [15:0] nv);
      derived_t d;
      d.v     = {nv[15:12], (nv[11:9] != 3'b111), 1'b0, 2'b11};
      d.ev    = {nv[3], nv[2], 1'b0, 2'b11, 3'b111};
      d.a4    = ~nv[0];
      d.upper = ~nv[1];
      return d;
   endfunction

endpackage

// File: rtl/spi_cfg_arm.sv
module spi_cfg_arm
   import spi_cfg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       op_valid,
   input  logic [7:0] op_code,
   output logic       armed,
   output logic       fire
);

   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (op_valid) begin
         armed_q <= (op_code == OP_ARM);
      end
   end

   assign armed = armed_q;
   assign fire  = op_valid && (op_code == OP_RST) && armed_q;

endmodule

// File: rtl/spi_cfg_collect.sv
module spi_cfg_collect
   import spi_cfg_pkg::*;
#(
   parameter int MAXB = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [7:0]        op_code,
   input  logic              wel,
   input  logic              data_valid,
   input  logic [7:0]        data_byte,
   input  logic              frame_end,
   input  logic              abort,
   output logic              commit,
   output tgt_e              commit_tgt,
   output logic [8*MAXB-1:0] commit_data
);

   localparam int CW = $clog2(MAXB + 1);

   if (MAXB < 2) begin : g_bad_maxb
      $error("spi_cfg_collect: MAXB must be at least 2");
   end

   tgt_e            tgt_q, dec_tgt;
   logic [CW-1:0]   need_q, got_q, dec_need;
   logic [8*MAXB-1:0] shadow_q;

   always_comb begin
      dec_tgt  = TGT_NONE;
      dec_need = '0;
      case (op_code)
         OP_WR_NV: begin dec_tgt = TGT_NV; dec_need = CW'(2); end
         OP_WR_V:  begin dec_tgt = TGT_V;  dec_need = CW'(1); end
         OP_WR_EV: begin dec_tgt = TGT_EV; dec_need = CW'(1); end
         OP_WR_EA: begin dec_tgt = TGT_EA; dec_need = CW'(1); end
         default:  ;
      endcase
   end

   assign commit     = data_valid && (tgt_q != TGT_NONE) && (got_q == need_q - CW'(1));
   assign commit_tgt = tgt_q;

   for (genvar i = 0; i < MAXB; i++) begin : g_lane
      assign commit_data[8*i +: 8] = (CW'(i) == got_q) ? data_byte :
                                     (CW'(i) <  got_q) ? shadow_q[8*i +: 8] : 8'h00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_q    <= TGT_NONE;
         need_q   <= '0;
         got_q    <= '0;
         shadow_q <= '0;
      end else if (abort || frame_end) begin
         tgt_q <= TGT_NONE;
      end else if (op_valid) begin
         tgt_q  <= (wel && dec_tgt != TGT_NONE) ? dec_tgt : TGT_NONE;
         need_q <= dec_need;
         got_q  <= '0;
      end else if (data_valid && tgt_q != TGT_NONE) begin
         for (int i = 0; i < MAXB; i++) begin
            if (CW'(i) == got_q) shadow_q[8*i +: 8] <= data_byte;
         end
         got_q <= got_q + CW'(1);
         if (commit) tgt_q <= TGT_NONE;
      end
   end

endmodule

// File: rtl/spi_cfg_readout.sv
module spi_cfg_readout
   import spi_cfg_pkg::*;
#(
   parameter int EAR_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [7:0]       op_code,
   input  logic             rd_req,
   input  logic             frame_end,
   input  logic             abort,
   input  logic [15:0]      nv,
   input  logic [7:0]       v,
   input  logic [7:0]       ev,
   input  logic [EAR_W-1:0] ea,
   output logic [7:0]       rd_byte
);

   tgt_e       sel_q, dec_sel;
   logic [1:0] idx_q, len;
   logic [7:0] ea8, src0, src1;

   if (EAR_W == 8) begin : g_ea_full
      assign ea8 = ea;
   end else begin : g_ea_pad
      assign ea8 = {{(8 - EAR_W){1'b0}}, ea};
   end

   always_comb begin
      case (op_code)
         OP_RD_NV: dec_sel = TGT_NV;
         OP_RD_V:  dec_sel = TGT_V;
         OP_RD_EV: dec_sel = TGT_EV;
         OP_RD_EA: dec_sel = TGT_EA;
         default:  dec_sel = TGT_NONE;
      endcase
   end

   always_comb begin
      src1 = 8'h00;
      case (sel_q)
         TGT_NV:  begin src0 = nv[7:0]; src1 = nv[15:8]; len = 2'd2; end
         TGT_V:   begin src0 = v;   len = 2'd1; end
         TGT_EV:  begin src0 = ev;  len = 2'd1; end
         TGT_EA:  begin src0 = ea8; len = 2'd1; end
         default: begin src0 = 8'h00; len = 2'd0; end
      endcase
   end

   assign rd_byte = (idx_q >= len) ? 8'h00 : (idx_q[0] ? src1 : src0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= TGT_NONE;
         idx_q <= '0;
      end else if (abort || frame_end) begin
         sel_q <= TGT_NONE;
         idx_q <= '0;
      end else if (op_valid) begin
         sel_q <= dec_sel;
         idx_q <= '0;
      end else if (rd_req && idx_q < len) begin
         idx_q <= idx_q + 2'd1;
      end
   end

endmodule

// File: rtl/spi_cfg_unit.sv
module spi_cfg_unit
   import spi_cfg_pkg::*;
#(
   parameter logic [15:0] NV_INIT   = 16'h8FFF,
   parameter int          EAR_W     = 8,
   parameter int          UPPER_SEG = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [7:0]       op_code,
   input  logic             data_valid,
   input  logic [7:0]       data_byte,
   input  logic             frame_end,
   input  logic             rd_req,
   output logic [7:0]       rd_byte,
   output logic [15:0]      cfg_nv,
   output logic [7:0]       cfg_v,
   output logic [7:0]       cfg_ev,
   output logic [EAR_W-1:0] ext_addr,
   output logic             addr4_mode,
   output logic             write_en,
   output logic             soft_rst
);

   localparam int       WR_BYTES = 2;
   localparam derived_t POR_CFG  = derive_cfg(NV_INIT);
   localparam logic [EAR_W-1:0] SEG_VAL = EAR_W'(UPPER_SEG);

   if (EAR_W < 2 || EAR_W > 8) begin : g_bad_ear
      $error("spi_cfg_unit: EAR_W must be within 2..8");
   end
   if (UPPER_SEG < 0 || UPPER_SEG >= (1 << EAR_W)) begin : g_bad_seg
      $error("spi_cfg_unit: UPPER_SEG does not fit EAR_W");
   end

   logic                  armed_w, fire_w, commit_w;
   tgt_e                  commit_tgt_w;
   logic [8*WR_BYTES-1:0] commit_data_w;
   derived_t              now_cfg;

   logic [15:0]      nv_q;
   logic [7:0]       v_q, ev_q;
   logic [EAR_W-1:0] ea_q;
   logic             a4_q, wel_q, srst_q;

   assign now_cfg = derive_cfg(nv_q);

   spi_cfg_arm u_arm (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_valid (op_valid),
      .op_code  (op_code),
      .armed    (armed_w),
      .fire     (fire_w)
   );

   spi_cfg_collect #(.MAXB(WR_BYTES)) u_collect (
      .clk         (clk),
      .rst_n       (rst_n),
      .op_valid    (op_valid),
      .op_code     (op_code),
      .wel         (wel_q),
      .data_valid  (data_valid),
      .data_byte   (data_byte),
      .frame_end   (frame_end),
      .abort       (fire_w),
      .commit      (commit_w),
      .commit_tgt  (commit_tgt_w),
      .commit_data (commit_data_w)
   );

   spi_cfg_readout #(.EAR_W(EAR_W)) u_readout (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .op_code   (op_code),
      .rd_req    (rd_req),
      .frame_end (frame_end),
      .abort     (fire_w),
      .nv        (nv_q),
      .v         (v_q),
      .ev        (ev_q),
      .ea        (ea_q),
      .rd_byte   (rd_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nv_q   <= NV_INIT;
         v_q    <= POR_CFG.v;
         ev_q   <= POR_CFG.ev;
         a4_q   <= POR_CFG.a4;
         ea_q   <= POR_CFG.upper ? SEG_VAL : '0;
         wel_q  <= 1'b0;
         srst_q <= 1'b0;
      end else begin
         srst_q <= fire_w;
         if (fire_w) begin
            v_q   <= now_cfg.v;
            ev_q  <= now_cfg.ev;
            a4_q  <= now_cfg.a4;
            ea_q  <= now_cfg.upper ? SEG_VAL : '0;
            wel_q <= 1'b0;
         end else begin
            if (op_valid && op_code == OP_WEN)    wel_q <= 1'b1;
            if (op_valid && op_code == OP_WDIS)   wel_q <= 1'b0;
            if (op_valid && op_code == OP_A4_ON)  a4_q  <= 1'b1;
            if (op_valid && op_code == OP_A4_OFF) a4_q  <= 1'b0;
            if (commit_w) begin
               case (commit_tgt_w)
                  TGT_NV:  nv_q <= commit_data_w[15:0];
                  TGT_V:   v_q  <= commit_data_w[7:0];
                  TGT_EV:  ev_q <= commit_data_w[7:0];
                  TGT_EA:  ea_q <= commit_data_w[EAR_W-1:0];
                  default: ;
               endcase
            end
         end
      end
   end

   assign cfg_nv     = nv_q;
   assign cfg_v      = v_q;
   assign cfg_ev     = ev_q;
   assign ext_addr   = ea_q;
   assign addr4_mode = a4_q;
   assign write_en   = wel_q;
   assign soft_rst   = srst_q;

endmodule

// File: rtl/spi_cfg_unit_chk.sv
module spi_cfg_unit_chk
   import spi_cfg_pkg::*;
#(
   parameter int EAR_W     = 8,
   parameter int UPPER_SEG = 3
)(
   input logic             clk,
   input logic             rst_n,
   input logic             op_valid,
   input logic [7:0]       op_code,
   input logic [7:0]       rd_byte,
   input logic [15:0]      cfg_nv,
   input logic [7:0]       cfg_v,
   input logic [7:0]       cfg_ev,
   input logic [EAR_W-1:0] ext_addr,
   input logic             addr4_mode,
   input logic             write_en,
   input logic             soft_rst,
   input logic             armed,
   input logic             commit
);

   // R2
   arm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_ARM) |=> armed);

   // R2
   arm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code != OP_ARM) |=> !armed);

   // R2
   unarmed_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_RST && !armed) |=> !soft_rst);

   // R2
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !soft_rst);

   // R3
   rst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |-> (!write_en && rd_byte == 8'h00));

   // R4
   vcfg_derive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |-> (cfg_v[1:0] == 2'b11 && !cfg_v[2] &&
                    cfg_v[3] == (cfg_nv[11:9] != 3'b111) &&
                    cfg_v[7:4] == cfg_nv[15:12]));

   // R5
   evcfg_derive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |-> (cfg_ev[4:0] == 5'h1F && !cfg_ev[5] &&
                    cfg_ev[6] == cfg_nv[2] && cfg_ev[7] == cfg_nv[3]));

   // R6
   addr_derive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |-> (addr4_mode == !cfg_nv[0] &&
                    ext_addr == (cfg_nv[1] ? '0 : EAR_W'(UPPER_SEG))));

   // R9
   nv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(cfg_nv));

   // R11
   nv_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |-> $stable(cfg_nv));

endmodule

bind spi_cfg_unit spi_cfg_unit_chk #(.EAR_W(EAR_W), .UPPER_SEG(UPPER_SEG)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_valid   (op_valid),
   .op_code    (op_code),
   .rd_byte    (rd_byte),
   .cfg_nv     (cfg_nv),
   .cfg_v      (cfg_v),
   .cfg_ev     (cfg_ev),
   .ext_addr   (ext_addr),
   .addr4_mode (addr4_mode),
   .write_en   (write_en),
   .soft_rst   (soft_rst),
   .armed      (armed_w),
   .commit     (commit_w)
);

// File: tb/tb_spi_cfg_unit.sv
module tb_spi_cfg_unit;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0, data_valid = 1'b0, frame_end = 1'b0, rd_req = 1'b0;
   logic [7:0] op_code = 8'h00, data_byte = 8'h00;
   logic [7:0] rd_byte, cfg_v, cfg_ev, ext_addr;
   logic [15:0] cfg_nv;
   logic       addr4_mode, write_en, soft_rst;

   int nchk = 0, nerr = 0;

   always #(CLK_P/2) clk = ~clk;

   spi_cfg_unit dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .data_valid(data_valid), .data_byte(data_byte), .frame_end(frame_end),
      .rd_req(rd_req), .rd_byte(rd_byte), .cfg_nv(cfg_nv), .cfg_v(cfg_v),
      .cfg_ev(cfg_ev), .ext_addr(ext_addr), .addr4_mode(addr4_mode),
      .write_en(write_en), .soft_rst(soft_rst)
   );

   // behavioural reference state
   int m_nv, m_v, m_ev, m_ea, m_tgt, m_need;
   bit m_a4, m_wel, m_armed, m_pulse;
   int colq[$];
   int rdq[$];

   function automatic void m_derive();
      bit xip;
      xip   = ((m_nv >> 9) & 7) != 7;
      m_v   = 3 | (xip ? 8 : 0) | (((m_nv >> 12) & 15) << 4);
      m_ev  = 31 | (((m_nv >> 2) & 1) ? 64 : 0) | (((m_nv >> 3) & 1) ? 128 : 0);
      m_a4  = (m_nv & 1) == 0;
      m_ea  = (m_nv & 2) ? 0 : 3;
      m_wel = 0;
   endfunction

   function automatic void m_apply(bit ov, int oc, bit dv, int db, bit fe, bit rr);
      bit fire;
      m_pulse = 0;
      if (ov) begin
         fire    = (oc == 'h99) && m_armed;
         m_armed = (oc == 'h66);
         rdq.delete();
         m_tgt = 0;
         if (fire) begin
            m_derive();
            m_pulse = 1;
         end else begin
            case (oc)
               'h06: m_wel = 1;
               'h04: m_wel = 0;
               'hB7: m_a4 = 1;
               'hE9: m_a4 = 0;
               'hB5: begin rdq.push_back(m_nv & 255); rdq.push_back(m_nv >> 8); end
               'h85: rdq.push_back(m_v);
               'h65: rdq.push_back(m_ev);
               'hC8: rdq.push_back(m_ea);
               'hB1: if (m_wel) begin m_tgt = 1; m_need = 2; end
               'h81: if (m_wel) begin m_tgt = 2; m_need = 1; end
               'h61: if (m_wel) begin m_tgt = 3; m_need = 1; end
               'hC5: if (m_wel) begin m_tgt = 4; m_need = 1; end
               default: ;
            endcase
            colq.delete();
         end
      end
      if (dv && m_tgt != 0) begin
         colq.push_back(db);
         if (colq.size() == m_need) begin
            case (m_tgt)
               1: m_nv = colq[0] | (colq[1] << 8);
               2: m_v  = colq[0];
               3: m_ev = colq[0];
               default: m_ea = colq[0];
            endcase
            m_tgt = 0;
         end
      end
      if (fe) begin
         m_tgt = 0;
         rdq.delete();
      end
      if (rr && rdq.size() > 0) void'(rdq.pop_front());
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R9",  "cfg_nv",     {16'h0, cfg_nv},     m_nv);
      chk("R4",  "cfg_v",      {24'h0, cfg_v},      m_v);
      chk("R5",  "cfg_ev",     {24'h0, cfg_ev},     m_ev);
      chk("R6",  "ext_addr",   {24'h0, ext_addr},   m_ea);
      chk("R6",  "addr4_mode", {31'h0, addr4_mode}, m_a4);
      chk("R10", "write_en",   {31'h0, write_en},   m_wel);
      chk("R2",  "soft_rst",   {31'h0, soft_rst},   m_pulse);
      chk("R7",  "rd_byte",    {24'h0, rd_byte},    rdq.size() > 0 ? rdq[0] : 0);
   endtask

   task automatic step(bit ov, logic [7:0] oc, bit dv, logic [7:0] db, bit fe, bit rr);
      @(negedge clk);
      compare_all();
      op_valid = ov; op_code = oc; data_valid = dv; data_byte = db;
      frame_end = fe; rd_req = rr;
      m_apply(ov, oc, dv, db, fe, rr);
   endtask

   task automatic op(logic [7:0] oc);  step(1, oc, 0, 8'h00, 0, 0); endtask
   task automatic dat(logic [7:0] b);  step(0, 8'h00, 1, b, 0, 0);  endtask
   task automatic fend();              step(0, 8'h00, 0, 8'h00, 1, 0); endtask
   task automatic rdn();               step(0, 8'h00, 0, 8'h00, 0, 1); endtask
   task automatic idle();              step(0, 8'h00, 0, 8'h00, 0, 0); endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
   endtask

   initial begin
      #(CLK_P * 150000);
      nchk++; nerr++;
      $display("FAIL watchdog: actual=expired expected=done");
      summary();
      $finish;
   end

   initial begin
      m_nv = 'h8FFF; m_derive(); m_armed = 0; m_pulse = 0; m_tgt = 0; m_need = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();
      // R1 power-on values
      chk("R1", "cfg_nv", cfg_nv, 16'h8FFF);
      chk("R1", "cfg_v", cfg_v, 8'h83);
      chk("R1", "cfg_ev", cfg_ev, 8'hDF);
      chk("R1", "ext_addr/addr4/wel", {ext_addr, addr4_mode, write_en}, 0);

      // R8 write without write enable is ignored
      op(8'hB1); dat(8'h0C); dat(8'h54); fend(); idle();
      chk("R8", "cfg_nv unchanged", cfg_nv, 16'h8FFF);

      // R10 write enable, R9 partial write discarded
      op(8'h06); idle();
      chk("R10", "write_en set", write_en, 1);
      op(8'hB1); dat(8'h0C); fend(); idle();
      chk("R9", "cut-short write", cfg_nv, 16'h8FFF);
      op(8'hB1); dat(8'h0C); idle();
      chk("R9", "before last byte", cfg_nv, 16'h8FFF);
      dat(8'h54); idle();
      chk("R9", "after last byte", cfg_nv, 16'h540C);
      dat(8'h77); idle();
      chk("R9", "surplus byte", cfg_nv, 16'h540C);
      fend();

      // R7 two-byte read, low byte first, then past the end
      op(8'hB5); idle();
      chk("R7", "nv byte0", rd_byte, 8'h0C);
      rdn(); idle();
      chk("R7", "nv byte1", rd_byte, 8'h54);
      rdn(); idle();
      chk("R7", "past end", rd_byte, 8'h00);
      fend();

      // R2 arm broken by another opcode
      op(8'h66); op(8'h05); op(8'h99); idle();
      chk("R2", "no reset after gap", {soft_rst, write_en}, 2'b01);
      op(8'h99); idle();
      chk("R2", "reset unarmed", soft_rst, 0);

      // R3 R4 R5 R6 R11 armed reset with nv=0x540C
      op(8'hB5); op(8'h66); op(8'h99); idle();
      chk("R2", "soft_rst pulse", soft_rst, 1);
      chk("R3", "wel cleared / read dropped", {write_en, rd_byte}, 0);
      chk("R4", "cfg_v derived", cfg_v, 8'h5B);
      chk("R5", "cfg_ev derived", cfg_ev, 8'hDF);
      chk("R6", "addr4/ext_addr", {addr4_mode, ext_addr}, {1'b1, 8'h03});
      chk("R11", "nv kept", cfg_nv, 16'h540C);
      idle();
      chk("R2", "pulse one cycle", soft_rst, 0);

      // R7 single-byte reads
      op(8'h85); idle(); chk("R7", "read v", rd_byte, 8'h5B);
      op(8'h65); idle(); chk("R7", "read ev", rd_byte, 8'hDF);
      op(8'hC8); idle(); chk("R7", "read ea", rd_byte, 8'h03);
      fend();

      // R8 R10 single-byte writes and mode opcodes
      op(8'h06);
      op(8'h81); dat(8'hA5); idle(); chk("R8", "write v", cfg_v, 8'hA5);
      op(8'h61); dat(8'h3C); idle(); chk("R8", "write ev", cfg_ev, 8'h3C);
      op(8'hC5); dat(8'h01); idle(); chk("R10", "write ea", ext_addr, 8'h01);
      op(8'hE9); idle(); chk("R10", "addr4 off", addr4_mode, 0);
      op(8'hB7); idle(); chk("R10", "addr4 on", addr4_mode, 1);
      op(8'h04); idle(); chk("R10", "write_en clear", write_en, 0);
      op(8'h81); dat(8'h11); idle(); chk("R8", "gated v write", cfg_v, 8'hA5);

      // R4 R5 R6 second derivation with nv=0x0E03
      op(8'h06); op(8'hB1); dat(8'h03); dat(8'h0E); fend();
      op(8'h66); op(8'h99); idle();
      chk("R4", "cfg_v derived 2", cfg_v, 8'h03);
      chk("R5", "cfg_ev derived 2", cfg_ev, 8'h1F);
      chk("R6", "addr4/ea derived 2", {addr4_mode, ext_addr}, 0);
      chk("R11", "nv kept 2", cfg_nv, 16'h0E03);
      idle(); idle();

      summary();
      $finish;
   end

endmodule